// File: doc/BRIEF.md
# Bidirectional FIFO Flag and Status Unit

This block keeps the fill level of two FIFO channels that carry data in opposite directions, A-to-B and B-to-A, each 1024 entries deep. It does not hold the data. It watches push and pop events for each channel and derives four conditions per channel: empty, almost-empty, full and almost-full. The almost thresholds come from four programmable offset registers. A routing register places any four of the eight conditions onto four shared flag pins, and a packed 16-bit status word shows all of them together with the transfer direction bit.

A small synchronous register port writes and reads the offsets, the routing register and the direction bit. A 3-bit reset command clears state selectively. It can clear one channel's level, both levels, only the pending transfer request, or everything including the configuration. The surrounding design drives pushes and pops from its memory pointer logic and reads the flags to throttle its ports.

Top module: `bififo_flag_unit`

## Requirements
- R1: Each channel keeps a level from 0 to 1024. A push adds one and a pop removes one. A push and a pop in the same cycle leave the level unchanged. A push at level 1024 and a pop at level 0 are ignored, so on an empty channel a simultaneous push and pop adds one.
- R2: Empty is 1 exactly at level 0 and full is 1 exactly at level 1024.
- R3: Almost-empty is 1 when level <= its offset. Almost-full is 1 when (1024 - level) <= its offset.
- R4: Offsets sit at addresses 0 (A-to-B almost-empty), 1 (A-to-B almost-full), 2 (B-to-A almost-empty) and 3 (B-to-A almost-full). A write keeps wdata[9:0] and drops the upper bits. A read returns the offset zero-extended. All offsets reset to 0.
- R5: The routing register is at address 4 and resets to 16'h6420. flag_pins[n] is selected by bits [4n+3:4n].
- R6: Routing codes: 0 A-to-B empty, 1 A-to-B almost-empty, 2 A-to-B full, 3 A-to-B almost-full, 4 B-to-A empty, 5 B-to-A almost-empty, 6 B-to-A full, 7 B-to-A almost-full. Codes 8 to 15 drive the pin to 0.
- R7: A read of address 5 gives the status word. Bit 3 is the direction. Bits 4..7 are A-to-B empty, A-to-B almost-empty, B-to-A full and B-to-A almost-full. Bits 12..15 are A-to-B full, A-to-B almost-full, B-to-A empty and B-to-A almost-empty. All other bits are 0, and so are reads of addresses 6 and 7.
- R8: Command 001 clears only the B-to-A level, 010 clears only the A-to-B level, and 011 clears both. None of them touches the offsets, routing, direction or request.
- R9: dma_req_set sets dma_req. Command 100 clears only dma_req, and it wins over a set in the same cycle.
- R10: Command 111 clears both levels and dma_req, sets the offsets to 0, the routing register to 16'h6420 and the direction to 0.
- R11: Commands 000, 101 and 110 change nothing. A command wins over a push, pop or register write in the same cycle.
- R12: Writing address 5 loads the direction from wdata[3]. The direction resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| push_ab | input | 1 | Write event on the A-to-B channel |
| pop_ab | input | 1 | Read event on the A-to-B channel |
| push_ba | input | 1 | Write event on the B-to-A channel |
| pop_ba | input | 1 | Read event on the B-to-A channel |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Combinational read data for reg_addr |
| rst_cmd_valid | input | 1 | Reset command strobe |
| rst_cmd | input | 3 | Reset command code |
| dma_req_set | input | 1 | Raises the internal transfer request |
| dma_req | output | 1 | Internal transfer request |
| flag_pins | output | 4 | Routed flags |

## Verification
A level counter that is off by one shows up as a status word that disagrees on the cycle after the event. The disagreement is sharpest next to a threshold or at 0 and 1024, so the checks walk the levels across those edges. A command that clears the wrong channel or a configuration register shows up on the very next read, in the other channel's flags, the offsets or the routing. A routing error changes the pins at once, combinationally. Every register's effect is visible at the ports within one cycle, so each check samples in the cycle right after its stimulus.

// File: rtl/bfu_pkg.sv
package bfu_pkg;
  localparam int unsigned NUM_PINS  = 4;
  localparam int unsigned CODE_W    = 4;
  localparam int unsigned NUM_FLAGS = 8;
  localparam int unsigned REG_W     = 16;
  localparam int unsigned ADDR_W    = 3;

  typedef enum logic [2:0] {
    RC_NONE = 3'b000,
    RC_BA   = 3'b001,
    RC_AB   = 3'b010,
    RC_BOTH = 3'b011,
    RC_REQ  = 3'b100,
    RC_ALL  = 3'b111
  } rst_code_e;

  typedef struct packed {
    logic afull;
    logic full;
    logic aempty;
    logic empty;
  } chan_flags_t;

  localparam logic [ADDR_W-1:0] A_AB_AE = 3'd0;
  localparam logic [ADDR_W-1:0] A_AB_AF = 3'd1;
  localparam logic [ADDR_W-1:0] A_BA_AE = 3'd2;
  localparam logic [ADDR_W-1:0] A_BA_AF = 3'd3;
  localparam logic [ADDR_W-1:0] A_ROUTE = 3'd4;
  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd5;
endpackage

// File: rtl/chan_occupancy.sv
module chan_occupancy
  import bfu_pkg::*;
#(
  parameter int unsigned DEPTH = 1024,
  localparam int unsigned OW = $clog2(DEPTH),
  localparam int unsigned CW = OW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          push,
  input  logic          pop,
  input  logic [OW-1:0] ae_off,
  input  logic [OW-1:0] af_off,
  output chan_flags_t   flags
);
  localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);
  localparam logic [CW-1:0] ONE      = CW'(1);

  logic [CW-1:0] level_q, level_d, free_lvl;
  logic          push_ok, pop_ok;

  assign push_ok = push && (level_q != FULL_LVL);
  assign pop_ok  = pop  && (level_q != '0);

  always_comb begin
    level_d = level_q;
    if (clear)                 level_d = '0;
    else if (push_ok && !pop_ok) level_d = level_q + ONE;
    else if (pop_ok && !push_ok) level_d = level_q - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= '0;
    else        level_q <= level_d;
  end

  assign free_lvl     = FULL_LVL - level_q;
  assign flags.empty  = (level_q == '0);
  assign flags.full   = (level_q == FULL_LVL);
  assign flags.aempty = (level_q <= {1'b0, ae_off});
  assign flags.afull  = (free_lvl <= {1'b0, af_off});

  p_level_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    level_q <= FULL_LVL);
  p_push_at_full_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (level_q == FULL_LVL && !pop && !clear) |=> level_q == FULL_LVL);
  p_pop_at_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (level_q == '0 && !push && !clear) |=> level_q == '0);
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> level_q == '0);
  p_flags_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(flags.empty && flags.full));
endmodule

// File: rtl/flag_router.sv
module flag_router
  import bfu_pkg::*;
#(
  parameter int unsigned PINS = NUM_PINS,
  parameter int unsigned CW   = CODE_W,
  localparam int unsigned SELW = $clog2(NUM_FLAGS)
) (
  input  logic [PINS*CW-1:0] route_cfg,
  input  chan_flags_t        ab_flags,
  input  chan_flags_t        ba_flags,
  output logic [PINS-1:0]    pins
);
  logic [NUM_FLAGS-1:0] flag_vec;
  assign flag_vec = {ba_flags, ab_flags};

  for (genvar n = 0; n < PINS; n++) begin : g_pin
    logic [CW-1:0] code;
    assign code = route_cfg[n*CW +: CW];
    always_comb begin
      if (code >= CW'(NUM_FLAGS)) pins[n] = 1'b0;
      else                        pins[n] = flag_vec[code[SELW-1:0]];
    end
  end
endmodule

// File: rtl/cfg_block.sv
module cfg_block
  import bfu_pkg::*;
#(
  parameter int unsigned OW = 10,
  parameter logic [REG_W-1:0] ROUTE_RESET = 16'h6420
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [REG_W-1:0]    wdata,
  input  logic                cmd_valid,
  input  logic [2:0]          cmd,
  input  logic                req_set,
  output logic [3:0][OW-1:0]  offsets,
  output logic [REG_W-1:0]    route,
  output logic                dir,
  output logic                req,
  output logic                clr_ab,
  output logic                clr_ba
);
  logic [3:0][OW-1:0] off_q, off_d;
  logic [REG_W-1:0]   route_q, route_d;
  logic               dir_q, dir_d, req_q, req_d;
  logic               cmd_all;

  assign cmd_all = cmd_valid && (cmd == RC_ALL);
  assign clr_ab  = cmd_valid && (cmd == RC_AB || cmd == RC_BOTH || cmd == RC_ALL);
  assign clr_ba  = cmd_valid && (cmd == RC_BA || cmd == RC_BOTH || cmd == RC_ALL);

  always_comb begin
    off_d   = off_q;
    route_d = route_q;
    dir_d   = dir_q;
    req_d   = req_q;
    if (wr_en) begin
      if (addr < A_ROUTE)       off_d[addr[1:0]] = wdata[OW-1:0];
      else if (addr == A_ROUTE) route_d = wdata;
      else if (addr == A_CTRL)  dir_d = wdata[3];
    end
    if (req_set) req_d = 1'b1;
    if (cmd_valid && cmd == RC_REQ) req_d = 1'b0;
    if (cmd_all) begin
      off_d   = '0;
      route_d = ROUTE_RESET;
      dir_d   = 1'b0;
      req_d   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q   <= '0;
      route_q <= ROUTE_RESET;
      dir_q   <= 1'b0;
      req_q   <= 1'b0;
    end else begin
      off_q   <= off_d;
      route_q <= route_d;
      dir_q   <= dir_d;
      req_q   <= req_d;
    end
  end

  assign offsets = off_q;
  assign route   = route_q;
  assign dir     = dir_q;
  assign req     = req_q;

  p_dir_keep_cfg_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd == RC_BA || cmd == RC_AB || cmd == RC_BOTH) && !wr_en)
    |=> ($stable(route_q) && $stable(off_q) && $stable(dir_q)));
  p_req_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd == RC_REQ) |=> !req_q);
  p_req_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_set && !cmd_valid) |=> req_q);
  p_reset_all_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_all |=> (route_q == ROUTE_RESET && off_q == '0 && !dir_q && !req_q));
endmodule

// File: rtl/bififo_flag_unit.sv
module bififo_flag_unit
  import bfu_pkg::*;
#(
  parameter int unsigned DEPTH = 1024,
  parameter logic [REG_W-1:0] ROUTE_RESET = 16'h6420,
  localparam int unsigned OW = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                push_ab,
  input  logic                pop_ab,
  input  logic                push_ba,
  input  logic                pop_ba,
  input  logic                reg_wr,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [REG_W-1:0]    reg_wdata,
  output logic [REG_W-1:0]    reg_rdata,
  input  logic                rst_cmd_valid,
  input  logic [2:0]          rst_cmd,
  input  logic                dma_req_set,
  output logic                dma_req,
  output logic [NUM_PINS-1:0] flag_pins
);
  logic rst_meta, srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      srst_n   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      srst_n   <= rst_meta;
    end
  end

  logic [3:0][OW-1:0] offsets;
  logic [REG_W-1:0]   route;
  logic               dir, clr_ab, clr_ba;
  chan_flags_t        ab_f, ba_f;
  logic [REG_W-1:0]   status;

  cfg_block #(.OW(OW), .ROUTE_RESET(ROUTE_RESET)) u_cfg (
    .clk(clk), .rst_n(srst_n), .wr_en(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .cmd_valid(rst_cmd_valid), .cmd(rst_cmd),
    .req_set(dma_req_set), .offsets(offsets), .route(route), .dir(dir),
    .req(dma_req), .clr_ab(clr_ab), .clr_ba(clr_ba)
  );

  chan_occupancy #(.DEPTH(DEPTH)) u_ab (
    .clk(clk), .rst_n(srst_n), .clear(clr_ab), .push(push_ab), .pop(pop_ab),
    .ae_off(offsets[0]), .af_off(offsets[1]), .flags(ab_f)
  );

  chan_occupancy #(.DEPTH(DEPTH)) u_ba (
    .clk(clk), .rst_n(srst_n), .clear(clr_ba), .push(push_ba), .pop(pop_ba),
    .ae_off(offsets[2]), .af_off(offsets[3]), .flags(ba_f)
  );

  flag_router #(.PINS(NUM_PINS), .CW(CODE_W)) u_route (
    .route_cfg(route), .ab_flags(ab_f), .ba_flags(ba_f), .pins(flag_pins)
  );

  always_comb begin
    status     = '0;
    status[3]  = dir;
    status[4]  = ab_f.empty;
    status[5]  = ab_f.aempty;
    status[6]  = ba_f.full;
    status[7]  = ba_f.afull;
    status[12] = ab_f.full;
    status[13] = ab_f.afull;
    status[14] = ba_f.empty;
    status[15] = ba_f.aempty;
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr < A_ROUTE)       reg_rdata = REG_W'(offsets[reg_addr[1:0]]);
    else if (reg_addr == A_ROUTE) reg_rdata = route;
    else if (reg_addr == A_CTRL)  reg_rdata = status;
  end

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_chk
    p_route_low_r6: assert property (@(posedge clk) disable iff (!srst_n)
      route[n*CODE_W + CODE_W - 1] |-> !flag_pins[n]);
  end
  p_status_zero_r7: assert property (@(posedge clk) disable iff (!srst_n)
    (reg_addr == A_CTRL) |-> (reg_rdata[2:0] == 3'b0 && reg_rdata[11:8] == 4'b0));
endmodule

// File: tb/tb_bififo_flag_unit.sv
module tb_bififo_flag_unit;
  localparam int DEPTH = 1024;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic push_ab = 0, pop_ab = 0, push_ba = 0, pop_ba = 0;
  logic reg_wr = 0;
  logic [2:0] reg_addr = 0;
  logic [15:0] reg_wdata = 0;
  logic [15:0] reg_rdata;
  logic rst_cmd_valid = 0;
  logic [2:0] rst_cmd = 0;
  logic dma_req_set = 0;
  logic dma_req;
  logic [3:0] flag_pins;

  always #10 clk = ~clk;

  bififo_flag_unit dut (
    .clk(clk), .rst_n(rst_n), .push_ab(push_ab), .pop_ab(pop_ab),
    .push_ba(push_ba), .pop_ba(pop_ba), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rst_cmd_valid(rst_cmd_valid),
    .rst_cmd(rst_cmd), .dma_req_set(dma_req_set), .dma_req(dma_req),
    .flag_pins(flag_pins)
  );

  // model
  int m_ab = 0, m_ba = 0;
  int m_off[4] = '{0, 0, 0, 0};
  logic [15:0] m_route = 16'h6420;
  logic m_dir = 0, m_req = 0;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  typedef struct {int kind; logic [15:0] exp; string tag;} item_t;
  item_t sb[$];

  function automatic logic [3:0] chf(int c, int ae, int af);
    logic [3:0] f;
    f[0] = (c == 0);
    f[1] = (c <= ae);
    f[2] = (c == DEPTH);
    f[3] = ((DEPTH - c) <= af);
    return f;
  endfunction

  function automatic logic [15:0] exp_status();
    logic [3:0] a, b;
    logic [15:0] s;
    a = chf(m_ab, m_off[0], m_off[1]);
    b = chf(m_ba, m_off[2], m_off[3]);
    s = 16'h0;
    s[3] = m_dir; s[4] = a[0]; s[5] = a[1]; s[6] = b[2]; s[7] = b[3];
    s[12] = a[2]; s[13] = a[3]; s[14] = b[0]; s[15] = b[1];
    return s;
  endfunction

  function automatic logic [3:0] exp_pins();
    logic [7:0] v;
    logic [3:0] p;
    v = {chf(m_ba, m_off[2], m_off[3]), chf(m_ab, m_off[0], m_off[1])};
    for (int n = 0; n < 4; n++) begin
      logic [3:0] c;
      c = m_route[n*4 +: 4];
      p[n] = c[3] ? 1'b0 : v[c[2:0]];
    end
    return p;
  endfunction

  // monitor: compares all pending expectations away from the active edge
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it;
      logic [15:0] act;
      it = sb.pop_front();
      case (it.kind)
        0: act = reg_rdata;
        1: act = {12'h0, flag_pins};
        default: act = {15'h0, dma_req};
      endcase
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
      end
    end
  end

  // one clock: model follows the inputs present at the edge
  task automatic tick();
    @(posedge clk);
    begin
      bit cab, cba;
      if (push_ab && m_ab < DEPTH && !(pop_ab && m_ab > 0)) m_ab++;
      else if (pop_ab && m_ab > 0 && !(push_ab && m_ab < DEPTH)) m_ab--;
      if (push_ba && m_ba < DEPTH && !(pop_ba && m_ba > 0)) m_ba++;
      else if (pop_ba && m_ba > 0 && !(push_ba && m_ba < DEPTH)) m_ba--;
      if (reg_wr) begin
        if (reg_addr < 4) m_off[reg_addr] = int'(reg_wdata[9:0]);
        else if (reg_addr == 4) m_route = reg_wdata;
        else if (reg_addr == 5) m_dir = reg_wdata[3];
      end
      if (dma_req_set) m_req = 1;
      cab = 0; cba = 0;
      if (rst_cmd_valid) begin
        case (rst_cmd)
          3'b001: cba = 1;
          3'b010: cab = 1;
          3'b011: begin cab = 1; cba = 1; end
          3'b100: m_req = 0;
          3'b111: begin
            cab = 1; cba = 1; m_req = 0; m_dir = 0; m_route = 16'h6420;
            for (int i = 0; i < 4; i++) m_off[i] = 0;
          end
          default: ;
        endcase
      end
      if (cab) m_ab = 0;
      if (cba) m_ba = 0;
    end
    #1;
    push_ab = 0; pop_ab = 0; push_ba = 0; pop_ba = 0;
    reg_wr = 0; rst_cmd_valid = 0; dma_req_set = 0;
  endtask

  task automatic run(bit pa, bit qa, bit pb, bit qb, int n);
    for (int i = 0; i < n; i++) begin
      push_ab = pa; pop_ab = qa; push_ba = pb; pop_ba = qb;
      tick();
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    tick();
  endtask

  task automatic cmd(logic [2:0] c);
    rst_cmd_valid = 1; rst_cmd = c;
    tick();
  endtask

  task automatic expect_reg(logic [2:0] a, logic [15:0] e, string tag);
    item_t it;
    reg_addr = a;
    it.kind = 0; it.exp = e; it.tag = tag;
    sb.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic expect_all(string tag);
    item_t it;
    reg_addr = 3'd5;
    it.kind = 0; it.exp = exp_status(); it.tag = {tag, " status"};
    sb.push_back(it);
    it.kind = 1; it.exp = {12'h0, exp_pins()}; it.tag = {tag, " pins"};
    sb.push_back(it);
    it.kind = 2; it.exp = {15'h0, m_req}; it.tag = {tag, " dma_req"};
    sb.push_back(it);
    @(negedge clk); #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (3) @(posedge clk);
    #1;
    // reset state
    expect_reg(3'd5, 16'hC030, "R7 reset status");
    expect_reg(3'd4, 16'h6420, "R5 reset route");
    expect_reg(3'd0, 16'h0000, "R4 reset offset");
    expect_all("R12 reset dir/pins");

    // offsets, upper bits dropped
    wr(3'd0, 16'hFC04);
    expect_reg(3'd0, 16'h0004, "R4 offset mask");
    wr(3'd1, 16'h0003);
    wr(3'd2, 16'h0001);
    wr(3'd3, 16'h03FF);
    expect_reg(3'd3, 16'h03FF, "R4 offset max");
    expect_all("R3 thresholds at zero level");

    // A-to-B walk across almost-empty edge
    run(1, 0, 0, 0, 4);
    expect_all("R3 level 4 at ae offset");
    run(1, 0, 0, 0, 1);
    expect_all("R3 level 5 past ae offset");
    run(1, 1, 0, 0, 3);
    expect_all("R1 push+pop holds");
    run(1, 0, 0, 0, 1016);
    expect_all("R3 level 1021 at af edge");
    run(1, 0, 0, 0, 3);
    expect_all("R2 full");
    run(1, 0, 0, 0, 3);
    expect_all("R1 push at full ignored");
    run(1, 1, 0, 0, 1);
    expect_all("R1 push+pop at full");

    // B-to-A: pop at empty, push+pop at empty
    run(0, 0, 0, 1, 2);
    expect_all("R1 pop at empty ignored");
    run(0, 0, 1, 1, 1);
    expect_all("R1 push+pop at empty");
    run(0, 0, 1, 0, 2);
    expect_all("R3 ba level 3");

    // routing codes
    wr(3'd4, 16'h7531);
    expect_all("R6 codes 1 3 5 7");
    wr(3'd4, 16'h2064);
    expect_all("R6 codes 4 6 0 2");
    wr(3'd4, 16'h8FA9);
    expect_all("R6 codes 8+ low");
    wr(3'd4, 16'h6F20);
    expect_all("R5 mixed");

    // direction and request
    wr(3'd5, 16'h0008);
    expect_all("R12 dir set");
    dma_req_set = 1; tick();
    expect_all("R9 req set");
    expect_reg(3'd6, 16'h0000, "R7 unused address");

    // no-op codes with traffic-free cycles
    cmd(3'b101);
    expect_all("R11 cmd 101");
    cmd(3'b110);
    cmd(3'b000);
    expect_all("R11 cmd 110/000");
    expect_reg(3'd0, 16'h0004, "R11 offsets kept");

    // selective clears
    cmd(3'b001);
    expect_all("R8 clear ba only");
    run(0, 0, 1, 0, 2);
    push_ab = 1;
    cmd(3'b010);
    expect_all("R11 clear ab beats push");
    expect_reg(3'd4, 16'h6F20, "R8 route kept");
    run(1, 0, 1, 0, 6);
    cmd(3'b011);
    expect_all("R8 clear both");
    expect_reg(3'd1, 16'h0003, "R8 offsets kept");

    // request clear wins over set
    dma_req_set = 1;
    cmd(3'b100);
    expect_all("R9 req clear wins");
    dma_req_set = 1; tick();
    run(1, 0, 1, 0, 7);

    // reset-all beats a write in the same cycle
    reg_wr = 1; reg_addr = 3'd4; reg_wdata = 16'h1111;
    cmd(3'b111);
    expect_all("R10 reset all");
    expect_reg(3'd4, 16'h6420, "R10 route default");
    expect_reg(3'd0, 16'h0000, "R10 offset cleared");
    expect_reg(3'd3, 16'h0000, "R10 offset3 cleared");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule